// File: doc/BRIEF.md
# System-Management Memory Window Controller

This block sits in the memory decode path of a host bridge and applies the system-management memory policy to every CPU request. Two control bytes set the policy. The window byte holds the open, lock and global-enable bits. The extended byte holds the high-alias enable and the top-segment enable and size. Both bytes are written through a small register port. Each write goes through a per-bit write mask, and that mask narrows to nothing once the lock bit is set.

Each request carries an address, a write flag and a flag for system-management mode. The block classifies the request against four regions: the legacy 128 KiB window at 0xA0000, its alias at 0xFEDA0000, the top segment just below the top of low memory, and everything else. It then routes the request to DRAM, to the PCI/VGA path, or to a blackhole that returns all ones on reads and drops writes. The current visibility of the windows and the active segment size are reported as outputs, so that neighbouring logic and the bench can observe the policy directly.

Top module: `smm_window_ctrl`

## Requirements
- R1: After reset both control bytes read 0x00, all four visibility outputs are 0, the segment size is 0 and no response is valid.
- R2: While unlocked, a write with `cfg_sel`=0 loads bits [2:0] of the window byte (bit0 open, bit1 lock, bit2 global enable), and a write with `cfg_sel`=1 loads bits [3:0] of the extended byte (bit0 high enable, bit1 segment enable, bits[3:2] size code). All other bits read 0.
- R3: Once the stored lock bit is 1, the open bit is forced to 0 in the same update. After that, writes to either byte change nothing until reset. Only reset clears the lock.
- R4: For a request outside system-management mode, the low window (0xA0000–0xBFFFF) is DRAM when open=1 and high enable=0; otherwise it goes to PCI/VGA.
- R5: For a request outside system-management mode, the high window (0xFEDA0000–0xFEDBFFFF) is DRAM only when open=1 and high enable=1; otherwise it goes to PCI/VGA.
- R6: For a request in system-management mode with global enable=1, the low window is DRAM when high enable=0 and the high window is DRAM when high enable=1. The non-SMM rules of R4 and R5 still apply on top of this.
- R7: The segment size is 1 MiB, 2 MiB or 8 MiB for size codes 0, 1 and 2 when segment enable=1. Code 3, or segment enable=0, gives a size of 0.
- R8: A request in [tolm − size, tolm) goes to DRAM in system-management mode and to the blackhole otherwise. A size of 0 creates no blackhole.
- R9: A blackhole read returns 0xFFFFFFFF. A blackhole write is not forwarded (`rsp_fwd_we`=0). For all other routes `rsp_fwd_we` equals the request's write flag and `rsp_rdata` is 0.
- R10: The response to a request appears exactly one cycle later. A register write is seen by requests from the following cycle onward, never by a request in the same cycle.
- R11: Any other address is DRAM below `tolm` and PCI/VGA at or above it. Route codes: 0 DRAM, 1 PCI/VGA, 2 blackhole.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control write strobe |
| cfg_sel | input | 1 | 0 selects window byte, 1 selects extended byte |
| cfg_wdata | input | 8 | Control write data |
| cfg_wctl | output | 8 | Stored window byte |
| cfg_xctl | output | 8 | Stored extended byte |
| tolm | input | 32 | Top of low memory (static) |
| req_valid | input | 1 | Request strobe |
| req_addr | input | 32 | Request byte address |
| req_we | input | 1 | Request is a write |
| req_smm | input | 1 | Request issued in system-management mode |
| rsp_valid | output | 1 | Response valid |
| rsp_route | output | 2 | 0 DRAM, 1 PCI/VGA, 2 blackhole |
| rsp_fwd_we | output | 1 | Write forwarded to its target |
| rsp_rdata | output | 32 | Blackhole read data, 0 otherwise |
| vis_low_norm | output | 1 | Low window is DRAM outside SMM |
| vis_high_norm | output | 1 | High window is DRAM outside SMM |
| vis_low_smm | output | 1 | Low window is DRAM in SMM |
| vis_high_smm | output | 1 | High window is DRAM in SMM |
| seg_size | output | 32 | Active top-segment size in bytes |

## Verification
The control bytes, visibility flags and segment size change at the clock edge that takes a write, so they are due one cycle after the write is driven. A routed response is due at the edge after its request, and it is decided by the control state from before that edge. The reference model follows the same order at every rising edge: it first derives the expected response from the old model state, then applies any write. All outputs are compared a nanosecond after that edge. Writes are deliberately issued in the same cycle as requests, which exposes any early use of new register values.

// File: rtl/smm_pkg.sv
package smm_pkg;
    typedef enum logic [1:0] {
        RT_DRAM = 2'd0,
        RT_PCI  = 2'd1,
        RT_HOLE = 2'd2
    } route_e;

    // window byte fields
    localparam int WB_OPEN = 0;
    localparam int WB_LOCK = 1;
    localparam int WB_GEN  = 2;
    // extended byte fields
    localparam int XB_HEN  = 0;
    localparam int XB_SEG  = 1;
    localparam int XB_SZLO = 2;

    localparam logic [7:0] WB_MASK_OPEN = 8'h07;
    localparam logic [7:0] WB_MASK_LOCK = 8'h00;
    localparam logic [7:0] XB_MASK_OPEN = 8'h0F;
    localparam logic [7:0] XB_MASK_LOCK = 8'h00;
    localparam logic [7:0] WB_RESET     = 8'h00;
    localparam logic [7:0] XB_RESET     = 8'h00;

    typedef struct packed {
        logic [7:0] wctl;
        logic [7:0] xctl;
    } ctl_s;
endpackage

// File: rtl/smm_ctl_regs.sv
module smm_ctl_regs
    import smm_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_we,
    input  logic       cfg_sel,
    input  logic [7:0] cfg_wdata,
    output logic [7:0] wctl,
    output logic [7:0] xctl
);
    ctl_s ctl_d, ctl_q;
    logic       locked;
    logic [7:0] wmask, xmask;

    always_comb begin
        locked = ctl_q.wctl[WB_LOCK];
        wmask  = locked ? WB_MASK_LOCK : WB_MASK_OPEN;
        xmask  = locked ? XB_MASK_LOCK : XB_MASK_OPEN;
        ctl_d  = ctl_q;
        if (cfg_we) begin
            if (!cfg_sel)
                ctl_d.wctl = (ctl_q.wctl & ~wmask) | (cfg_wdata & wmask);
            else
                ctl_d.xctl = (ctl_q.xctl & ~xmask) | (cfg_wdata & xmask);
        end
        if (ctl_d.wctl[WB_LOCK])
            ctl_d.wctl[WB_OPEN] = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q.wctl <= WB_RESET;
            ctl_q.xctl <= XB_RESET;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    assign wctl = ctl_q.wctl;
    assign xctl = ctl_q.xctl;

    // R3: the lock survives every cycle until reset
    p_lock_sticky_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wctl[WB_LOCK] |=> ctl_q.wctl[WB_LOCK]);
    // R3: a locked controller keeps the open bit clear
    p_lock_closed_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_q.wctl[WB_LOCK] |-> !ctl_q.wctl[WB_OPEN]);
    // R3: writes to a locked controller leave both bytes unchanged
    p_lock_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.wctl[WB_LOCK] && cfg_we) |=> $stable(ctl_q));
endmodule

// File: rtl/smm_policy.sv
module smm_policy
    import smm_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [7:0]    wctl,
    input  logic [7:0]    xctl,
    input  logic [AW-1:0] tolm,
    output logic          low_norm,
    output logic          high_norm,
    output logic          low_smm,
    output logic          high_smm,
    output logic [AW-1:0] seg_size,
    output logic [AW-1:0] seg_base
);
    localparam logic [AW-1:0] SZ_1M = AW'(32'h0010_0000);
    localparam logic [AW-1:0] SZ_2M = AW'(32'h0020_0000);
    localparam logic [AW-1:0] SZ_8M = AW'(32'h0080_0000);

    logic open_b, gen_b, hen_b;

    always_comb begin
        open_b    = wctl[WB_OPEN];
        gen_b     = wctl[WB_GEN];
        hen_b     = xctl[XB_HEN];
        low_norm  = open_b & ~hen_b;
        high_norm = open_b &  hen_b;
        low_smm   = low_norm  | (gen_b & ~hen_b);
        high_smm  = high_norm | (gen_b &  hen_b);
        seg_size  = '0;
        if (xctl[XB_SEG]) begin
            unique case (xctl[XB_SZLO +: 2])
                2'd0:    seg_size = SZ_1M;
                2'd1:    seg_size = SZ_2M;
                2'd2:    seg_size = SZ_8M;
                default: seg_size = '0;
            endcase
        end
        seg_base = tolm - seg_size;
    end
endmodule

// File: rtl/smm_router.sv
module smm_router
    import smm_pkg::*;
#(
    parameter int          AW        = 32,
    parameter int          DW        = 32,
    parameter logic [31:0] LOW_BASE  = 32'h000A_0000,
    parameter logic [31:0] HIGH_BASE = 32'hFEDA_0000,
    parameter logic [31:0] WIN_SIZE  = 32'h0002_0000
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_we,
    input  logic          req_smm,
    input  logic          low_norm,
    input  logic          high_norm,
    input  logic          low_smm,
    input  logic          high_smm,
    input  logic [AW-1:0] seg_size,
    input  logic [AW-1:0] seg_base,
    input  logic [AW-1:0] tolm,
    output logic          rsp_valid,
    output route_e        rsp_route,
    output logic          rsp_fwd_we,
    output logic [DW-1:0] rsp_rdata
);
    localparam logic [AW:0] LO_LO = (AW+1)'(LOW_BASE);
    localparam logic [AW:0] LO_HI = (AW+1)'(LOW_BASE) + (AW+1)'(WIN_SIZE);
    localparam logic [AW:0] HI_LO = (AW+1)'(HIGH_BASE);
    localparam logic [AW:0] HI_HI = (AW+1)'(HIGH_BASE) + (AW+1)'(WIN_SIZE);

    typedef struct packed {
        logic          valid;
        route_e        route;
        logic          fwd_we;
        logic [DW-1:0] rdata;
    } rsp_s;

    rsp_s        rsp_d, rsp_q;
    logic [AW:0] a_ext;
    logic        in_low, in_high, in_seg, show;

    always_comb begin
        a_ext   = {1'b0, req_addr};
        in_low  = (a_ext >= LO_LO) && (a_ext < LO_HI);
        in_high = (a_ext >= HI_LO) && (a_ext < HI_HI);
        in_seg  = (seg_size != '0) && (req_addr >= seg_base) && (req_addr < tolm);
        show    = 1'b0;
        rsp_d   = '0;
        rsp_d.valid = req_valid;
        if (req_valid) begin
            if (in_high) begin
                show        = req_smm ? high_smm : high_norm;
                rsp_d.route = show ? RT_DRAM : RT_PCI;
            end else if (in_low) begin
                show        = req_smm ? low_smm : low_norm;
                rsp_d.route = show ? RT_DRAM : RT_PCI;
            end else if (in_seg) begin
                rsp_d.route = req_smm ? RT_DRAM : RT_HOLE;
            end else begin
                rsp_d.route = (req_addr < tolm) ? RT_DRAM : RT_PCI;
            end
            if (rsp_d.route == RT_HOLE) begin
                rsp_d.fwd_we = 1'b0;
                rsp_d.rdata  = req_we ? '0 : '1;
            end else begin
                rsp_d.fwd_we = req_we;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_valid  = rsp_q.valid;
    assign rsp_route  = rsp_q.route;
    assign rsp_fwd_we = rsp_q.fwd_we;
    assign rsp_rdata  = rsp_q.rdata;

    // R10: every request is answered in the next cycle
    p_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R10: no response without a request
    p_no_spurious_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9: the blackhole never forwards a write
    p_hole_drop_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_route == RT_HOLE) |-> !rsp_fwd_we);
    // R8: a system-management request never lands in the blackhole
    p_smm_no_hole_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_smm) |=> rsp_route != RT_HOLE);
endmodule

// File: rtl/smm_window_ctrl.sv
module smm_window_ctrl
    import smm_pkg::*;
#(
    parameter int AW = 32,
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic          cfg_sel,
    input  logic [7:0]    cfg_wdata,
    output logic [7:0]    cfg_wctl,
    output logic [7:0]    cfg_xctl,
    input  logic [AW-1:0] tolm,
    input  logic          req_valid,
    input  logic [AW-1:0] req_addr,
    input  logic          req_we,
    input  logic          req_smm,
    output logic          rsp_valid,
    output logic [1:0]    rsp_route,
    output logic          rsp_fwd_we,
    output logic [DW-1:0] rsp_rdata,
    output logic          vis_low_norm,
    output logic          vis_high_norm,
    output logic          vis_low_smm,
    output logic          vis_high_smm,
    output logic [AW-1:0] seg_size
);
    logic [AW-1:0] seg_base;
    route_e        route_w;

    smm_ctl_regs u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .wctl      (cfg_wctl),
        .xctl      (cfg_xctl)
    );

    smm_policy #(.AW(AW)) u_policy (
        .wctl      (cfg_wctl),
        .xctl      (cfg_xctl),
        .tolm      (tolm),
        .low_norm  (vis_low_norm),
        .high_norm (vis_high_norm),
        .low_smm   (vis_low_smm),
        .high_smm  (vis_high_smm),
        .seg_size  (seg_size),
        .seg_base  (seg_base)
    );

    smm_router #(.AW(AW), .DW(DW)) u_router (
        .clk        (clk),
        .rst_n      (rst_n),
        .req_valid  (req_valid),
        .req_addr   (req_addr),
        .req_we     (req_we),
        .req_smm    (req_smm),
        .low_norm   (vis_low_norm),
        .high_norm  (vis_high_norm),
        .low_smm    (vis_low_smm),
        .high_smm   (vis_high_smm),
        .seg_size   (seg_size),
        .seg_base   (seg_base),
        .tolm       (tolm),
        .rsp_valid  (rsp_valid),
        .rsp_route  (route_w),
        .rsp_fwd_we (rsp_fwd_we),
        .rsp_rdata  (rsp_rdata)
    );

    assign rsp_route = route_w;

    // R7: the segment size is one of the power-of-two sizes or zero
    p_seg_pow2_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(seg_size) <= 1);
    // R3: a locked controller shows no open-mode DRAM view outside SMM
    p_lock_hides_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wctl[WB_LOCK] |-> !(vis_low_norm || vis_high_norm));
endmodule

// File: tb/sim_smm_window_ctrl.sv
`timescale 1ns/1ps
module sim_smm_window_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0, cfg_sel = 1'b0;
    logic [7:0]  cfg_wdata = '0;
    logic [7:0]  cfg_wctl, cfg_xctl;
    logic [31:0] tolm = 32'h8000_0000;
    logic        req_valid = 1'b0, req_we = 1'b0, req_smm = 1'b0;
    logic [31:0] req_addr = '0;
    logic        rsp_valid, rsp_fwd_we;
    logic [1:0]  rsp_route;
    logic [31:0] rsp_rdata, seg_size;
    logic        vis_low_norm, vis_high_norm, vis_low_smm, vis_high_smm;

    int tests = 0;
    int fails = 0;
    bit done  = 0;

    always #2.5 clk = ~clk;

    smm_window_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
        .cfg_wdata(cfg_wdata), .cfg_wctl(cfg_wctl), .cfg_xctl(cfg_xctl),
        .tolm(tolm), .req_valid(req_valid), .req_addr(req_addr),
        .req_we(req_we), .req_smm(req_smm), .rsp_valid(rsp_valid),
        .rsp_route(rsp_route), .rsp_fwd_we(rsp_fwd_we), .rsp_rdata(rsp_rdata),
        .vis_low_norm(vis_low_norm), .vis_high_norm(vis_high_norm),
        .vis_low_smm(vis_low_smm), .vis_high_smm(vis_high_smm),
        .seg_size(seg_size)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // ---------------- reference model ----------------
    int unsigned mw = 0, mx = 0;
    bit          ev = 0, efw = 0;
    int          er = 0;
    longint      erd = 0;
    string       etag = "R11";

    function automatic longint msize(int unsigned x);
        if (((x >> 1) & 1) == 0) return 0;
        case ((x >> 2) & 3)
            0: return 64'h10_0000;
            1: return 64'h20_0000;
            2: return 64'h80_0000;
            default: return 0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            mw = 0; mx = 0; ev = 0;
        end else begin
            ev = req_valid;
            if (req_valid) begin
                longint a, t, sz;
                bit op, ge, he, lk;
                a  = longint'(req_addr);
                t  = longint'(tolm);
                sz = msize(mx);
                op = mw[0]; lk = mw[1]; ge = mw[2]; he = mx[0];
                if (a >= 64'hFEDA_0000 && a < 64'hFEDC_0000) begin
                    etag = "R5,R6";
                    er = ((op && he) || (req_smm && ge && he)) ? 0 : 1;
                end else if (a >= 64'hA_0000 && a < 64'hC_0000) begin
                    etag = "R4,R6";
                    er = ((op && !he) || (req_smm && ge && !he)) ? 0 : 1;
                end else if (sz != 0 && a >= t - sz && a < t) begin
                    etag = "R8";
                    er = req_smm ? 0 : 2;
                end else begin
                    etag = "R11";
                    er = (a < t) ? 0 : 1;
                end
                efw = (er == 2) ? 1'b0 : req_we;
                erd = (er == 2 && !req_we) ? 64'hFFFF_FFFF : 0;
            end
            if (cfg_we && mw[1] == 0) begin
                if (!cfg_sel) mw = cfg_wdata & 8'h07;
                else          mx = cfg_wdata & 8'h0F;
            end
            if (mw[1]) mw[0] = 0;
        end
        #1;
        if (!done) begin
            chk(rsp_valid == ev, "R10 valid", rsp_valid, ev);
            if (ev) begin
                chk(rsp_route == er, etag, rsp_route, er);
                chk(rsp_fwd_we == efw, "R9 fwd", rsp_fwd_we, efw);
                chk(rsp_rdata == erd, "R9 rdata", rsp_rdata, erd);
            end
            chk(cfg_wctl == mw, "R2,R3 wctl", cfg_wctl, mw);
            chk(cfg_xctl == mx, "R2,R3 xctl", cfg_xctl, mx);
            chk(seg_size == msize(mx), "R7 size", seg_size, msize(mx));
            chk({vis_low_norm, vis_high_norm, vis_low_smm, vis_high_smm} ==
                {mw[0] && !mx[0], mw[0] && mx[0],
                 (mw[0] || mw[2]) && !mx[0], (mw[0] || mw[2]) && mx[0]},
                "R4,R5,R6 vis",
                {vis_low_norm, vis_high_norm, vis_low_smm, vis_high_smm},
                {mw[0] && !mx[0], mw[0] && mx[0],
                 (mw[0] || mw[2]) && !mx[0], (mw[0] || mw[2]) && mx[0]});
        end
    end

    // ---------------- stimulus ----------------
    task automatic cyc(input bit we, input bit sel, input logic [7:0] wd,
                       input bit rv, input logic [31:0] a, input bit rw, input bit smm);
        @(negedge clk);
        cfg_we = we; cfg_sel = sel; cfg_wdata = wd;
        req_valid = rv; req_addr = a; req_we = rw; req_smm = smm;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(0, 0, 8'h00, 0, 32'h0, 0, 0);
    endtask

    logic [31:0] alist [16];

    initial begin
        alist[0]  = 32'h0000_1000;  alist[1]  = 32'h000A_0000;
        alist[2]  = 32'h000B_FFFF;  alist[3]  = 32'h000C_0000;
        alist[4]  = 32'hFEDA_0000;  alist[5]  = 32'hFEDB_FFFC;
        alist[6]  = 32'hFEDC_0000;  alist[7]  = 32'h7FFF_FFFC;
        alist[8]  = 32'h7FF0_0000;  alist[9]  = 32'h7FEF_FFFC;
        alist[10] = 32'h7FE0_0000;  alist[11] = 32'h7FDF_FFFC;
        alist[12] = 32'h7F80_0000;  alist[13] = 32'h7F7F_FFFC;
        alist[14] = 32'h8000_0000;  alist[15] = 32'hFFFF_FFF0;

        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        // R1: reset state
        #0.5;
        chk(cfg_wctl == 8'h00 && cfg_xctl == 8'h00, "R1 bytes", {cfg_wctl, cfg_xctl}, 0);
        chk({vis_low_norm, vis_high_norm, vis_low_smm, vis_high_smm} == 4'b0, "R1 vis",
            {vis_low_norm, vis_high_norm, vis_low_smm, vis_high_smm}, 0);
        chk(seg_size == 0 && !rsp_valid, "R1 idle", seg_size, 0);

        // R2: bits outside the writable fields read 0
        cyc(1, 1, 8'hFF, 0, 0, 0, 0);
        cyc(1, 0, 8'hF8, 0, 0, 0, 0);
        idle(1);
        chk(cfg_xctl == 8'h0F, "R2 xmask", cfg_xctl, 8'h0F);
        chk(cfg_wctl == 8'h00, "R2 wmask", cfg_wctl, 8'h00);

        // full sweep of unlocked policies (R4 to R9, R11); the extended byte
        // is written while a request is in flight (R10)
        foreach (alist[k]) begin end
        for (int w = 0; w < 8; w++) begin
            if (w[1]) continue;
            for (int x = 0; x < 16; x++) begin
                cyc(1, 0, 8'(w), 1, alist[0], 0, 0);
                cyc(1, 1, 8'(x), 1, alist[1], 1, 1);
                for (int k = 0; k < 16; k++)
                    for (int m = 0; m < 4; m++)
                        cyc(0, 0, 8'h00, 1, alist[k], m[0], m[1]);
            end
        end
        idle(2);

        // R3: lock with open and global enable requested, open drops
        cyc(1, 1, 8'h07, 0, 0, 0, 0);
        cyc(1, 0, 8'h07, 0, 0, 0, 0);
        idle(1);
        chk(cfg_wctl == 8'h06, "R3 lock clears open", cfg_wctl, 8'h06);
        cyc(1, 0, 8'h00, 1, 32'h7FF0_0000, 0, 0);
        cyc(1, 1, 8'h00, 1, 32'h7FF0_0000, 1, 0);
        idle(1);
        chk(cfg_wctl == 8'h06 && cfg_xctl == 8'h07, "R3 frozen",
            {cfg_wctl, cfg_xctl}, 16'h0607);
        for (int k = 0; k < 16; k++)
            for (int m = 0; m < 4; m++)
                cyc(m[0], m[1], 8'h01, 1, alist[k], m[0], m[1]);
        idle(1);

        // R3: only reset releases the lock
        @(negedge clk); rst_n = 1'b0;
        idle(2);
        @(negedge clk); rst_n = 1'b1;
        #0.5;
        chk(cfg_wctl == 8'h00, "R3 reset unlock", cfg_wctl, 0);
        cyc(1, 0, 8'h01, 0, 0, 0, 0);
        idle(1);
        chk(cfg_wctl == 8'h01, "R3 writable after reset", cfg_wctl, 8'h01);

        // R9 explicit: blackhole read and write
        cyc(1, 1, 8'h02, 0, 0, 0, 0);
        cyc(0, 0, 8'h00, 1, 32'h7FF8_0000, 0, 0);
        @(posedge clk); #1.5;
        chk(rsp_route == 2 && rsp_rdata == 32'hFFFF_FFFF, "R9 hole read",
            rsp_rdata, 32'hFFFF_FFFF);
        cyc(0, 0, 8'h00, 1, 32'h7FF8_0000, 1, 0);
        @(posedge clk); #1.5;
        chk(rsp_route == 2 && !rsp_fwd_we, "R9 hole write", rsp_fwd_we, 0);
        idle(3);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            tests++; fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule